// File: doc/BRIEF.md
# Pulse-Count Current-Limit Decoder

This block turns a short burst of pulses on a single enable line into a 4-bit peak-current-limit code for a flyback switch controller. The line is asynchronous to the system clock. It passes through a synchronizer, and the block then tracks its rising edges.

The first rising edge enables the device and opens a programming window of fixed length. That first high phase must be long; a short one marks the burst as invalid. Each further rising edge inside the window steps the limit down by one level. When the window ends with the line high, the code is latched, a level ready flag rises and a one-cycle strobe marks the moment. The switch controller waits on the ready flag before it starts switching.

Taking the line low disables the device and clears the setting, so a new code needs a fresh burst. A combinational lookup turns the code into a percentage of the full-scale limit.

Top module: `ilim_burst_decoder`

## Requirements
- R1: While reset is held and after it is released with the line low, ready_o and setup_done_o are 0, level_o is 0 and pct_o is 100.
- R2: A burst whose first high phase lasts at least FIRST_MIN_CYC clock cycles, with no further rising edge, locks level_o at 0.
- R3: Each extra rising edge after a valid first high phase, arriving before the window ends, raises the locked level_o by one, so N extra edges (N up to 15) give level_o = N.
- R4: pct_o maps level_o 0 through 15 to 100, 95, 90, 86, 81, 76, 71, 67, 62, 57, 52, 48, 43, 38, 33, 29 in that order.
- R5: Extra rising edges beyond the fifteenth are ignored, and level_o saturates at 15.
- R6: A first high phase shorter than FIRST_MIN_CYC cycles rejects the burst. Its later edges are ignored and level_o locks at 0. A first high phase of exactly FIRST_MIN_CYC cycles is accepted.
- R7: ready_o rises on the clock edge WINDOW_CYC+2 edges after the first edge that samples the line high. setup_done_o is high for exactly that one cycle.
- R8: Taking the line low while locked clears ready_o and level_o within three clock edges. A new code needs a fresh burst.
- R9: If the line is low when the window ends, nothing is locked: ready_o stays 0 and level_o stays 0.
- R10: While the line stays high after locking, level_o and ready_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_line_i | input | 1 | Asynchronous enable/programming line |
| level_o | output | 4 | Latched limit code, 0 = full scale |
| pct_o | output | 7 | Limit as a percentage of full scale |
| ready_o | output | 1 | Level flag: code latched and valid |
| setup_done_o | output | 1 | One-cycle strobe when the code latches |

## Verification
The bench targets the edges of the timing rules:
- It uses a first high phase of exactly the minimum width and one a single cycle short. A design that compares off by one would either reject a legal burst or lock a nonzero code from an invalid one.
- It sends bursts of one-cycle pulses and one of twenty extra pulses. A design that misses fast edges would report a low count; one that wraps instead of saturating would report code 4.
- It pins the cycle on which ready rises. This catches a window timer that is off by one.
- It ends a burst with the line low at window close. A design that latches anyway would assert ready on a disabled device.

// File: rtl/ilim_pkg.sv
package ilim_pkg;
  localparam int unsigned LEVEL_W = 4;
  localparam int unsigned PCT_W   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_WINDOW,
    ST_REJECT,
    ST_LOCKED
  } dec_state_e;

  typedef logic [LEVEL_W-1:0] level_t;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import ilim_pkg::*;
#(
  parameter int unsigned FIRST_MIN_CYC = 750,
  parameter int unsigned WINDOW_CYC    = 10000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   line_s_i,
  output level_t level_o,
  output logic   ready_o,
  output logic   done_o
);
  localparam int unsigned TIMER_W = $clog2(WINDOW_CYC + 1);
  localparam level_t      CNT_MAX = '1;

  dec_state_e       state_q, state_n;
  logic [TIMER_W-1:0] timer_q, timer_n;
  level_t           cnt_q, cnt_n, level_q, level_n;
  logic             ready_q, ready_n, done_n, done_q;
  logic             line_d_q;
  logic             rise, expire;

  assign rise   = line_s_i & ~line_d_q;
  assign expire = (timer_q == TIMER_W'(WINDOW_CYC));

  always_comb begin
    state_n = state_q;
    timer_n = timer_q;
    cnt_n   = cnt_q;
    level_n = level_q;
    ready_n = ready_q;
    done_n  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        level_n = '0;
        ready_n = 1'b0;
        if (rise) begin
          state_n = ST_FIRST;
          timer_n = TIMER_W'(1);   // rise cycle is the first high cycle
          cnt_n   = '0;
        end
      end
      ST_FIRST, ST_WINDOW, ST_REJECT: begin
        timer_n = timer_q + 1'b1;
        if (expire) begin
          timer_n = '0;
          if (line_s_i) begin
            state_n = ST_LOCKED;
            level_n = (state_q == ST_WINDOW) ? cnt_q : '0;
            ready_n = 1'b1;
            done_n  = 1'b1;
          end else begin
            state_n = ST_IDLE;
          end
        end else if (state_q == ST_FIRST) begin
          if (!line_s_i)
            state_n = (timer_q >= TIMER_W'(FIRST_MIN_CYC)) ? ST_WINDOW : ST_REJECT;
        end else if (state_q == ST_WINDOW) begin
          if (rise && cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
        end
      end
      ST_LOCKED: begin
        if (!line_s_i) begin
          state_n = ST_IDLE;
          level_n = '0;
          ready_n = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      timer_q  <= '0;
      cnt_q    <= '0;
      level_q  <= '0;
      ready_q  <= 1'b0;
      done_q   <= 1'b0;
      line_d_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      timer_q  <= timer_n;
      cnt_q    <= cnt_n;
      level_q  <= level_n;
      ready_q  <= ready_n;
      done_q   <= done_n;
      line_d_q <= line_s_i;
    end
  end

  assign level_o = level_q;
  assign ready_o = ready_q;
  assign done_o  = done_q;

  // R10
  hold_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q && $past(ready_q) |-> $stable(level_q));

  // R7
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ready_q && !$past(ready_q));

  // R7
  strobe_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> done_q);

  // R8
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_q |-> level_q == '0);

  // R7
  window_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_q <= TIMER_W'(WINDOW_CYC));

  // R8
  low_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q && !line_s_i |=> !ready_q);
endmodule

// File: rtl/pct_lookup.sv
module pct_lookup
  import ilim_pkg::*;
(
  input  level_t           level_i,
  output logic [PCT_W-1:0] pct_o
);
  always_comb begin
    unique case (level_i)
      4'd0:  pct_o = 7'd100;
      4'd1:  pct_o = 7'd95;
      4'd2:  pct_o = 7'd90;
      4'd3:  pct_o = 7'd86;
      4'd4:  pct_o = 7'd81;
      4'd5:  pct_o = 7'd76;
      4'd6:  pct_o = 7'd71;
      4'd7:  pct_o = 7'd67;
      4'd8:  pct_o = 7'd62;
      4'd9:  pct_o = 7'd57;
      4'd10: pct_o = 7'd52;
      4'd11: pct_o = 7'd48;
      4'd12: pct_o = 7'd43;
      4'd13: pct_o = 7'd38;
      4'd14: pct_o = 7'd33;
      default: pct_o = 7'd29;
    endcase
  end
endmodule

// File: rtl/ilim_burst_decoder.sv
module ilim_burst_decoder
  import ilim_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned FIRST_MIN_CYC = 750,
  parameter int unsigned WINDOW_CYC    = 10000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         prog_line_i,
  output logic [3:0]   level_o,
  output logic [6:0]   pct_o,
  output logic         ready_o,
  output logic         setup_done_o
);
  logic   line_s;
  level_t level;

  line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (prog_line_i),
    .q_o    (line_s)
  );

  burst_ctrl #(
    .FIRST_MIN_CYC (FIRST_MIN_CYC),
    .WINDOW_CYC    (WINDOW_CYC)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_s_i (line_s),
    .level_o  (level),
    .ready_o  (ready_o),
    .done_o   (setup_done_o)
  );

  pct_lookup u_pct (
    .level_i (level),
    .pct_o   (pct_o)
  );

  assign level_o = level;

  // R4
  pct_full_scale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> pct_o == 7'd100);
endmodule

// File: tb/ilim_burst_decoder_bench.sv
`timescale 1ns/1ps
module ilim_burst_decoder_bench;
  localparam int FMIN = 40;
  localparam int WIN  = 400;
  localparam int NVEC = 8;
  // first_hi, extra pulses, pulse high, pulse low, expected level
  localparam int VEC [NVEC][5] = '{
    '{60, 0, 2, 2, 0},
    '{60, 1, 2, 2, 1},
    '{FMIN, 4, 3, 5, 4},
    '{FMIN-1, 3, 2, 2, 0},
    '{100, 15, 1, 1, 15},
    '{60, 20, 2, 2, 15},
    '{60, 7, 5, 3, 7},
    '{60, 12, 1, 2, 12}
  };
  localparam int PCT [16] = '{100, 95, 90, 86, 81, 76, 71, 67,
                              62, 57, 52, 48, 43, 38, 33, 29};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog = 1'b0;
  logic [3:0] level;
  logic [6:0] pct;
  logic       ready, sdone;
  int checks = 0;
  int fails  = 0;
  int e;

  always #2.5 clk = ~clk;

  ilim_burst_decoder #(.FIRST_MIN_CYC(FMIN), .WINDOW_CYC(WIN)) u_ilim_burst_decoder (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .prog_line_i  (prog),
    .level_o      (level),
    .pct_o        (pct),
    .ready_o      (ready),
    .setup_done_o (sdone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      e++;
    end
    @(negedge clk);
  endtask

  // drive a burst; e counts edges from the first edge that samples the line high
  task automatic burst(input int first_hi, input int n_extra, input int hi, input int lo);
    prog = 1'b1;
    e = 0;
    edges(first_hi);
    for (int p = 0; p < n_extra; p++) begin
      prog = 1'b0;
      edges(lo);
      prog = 1'b1;
      edges(hi);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 0 && sdone == 0 && level == 0, "R1 in reset", int'(ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ready == 0 && sdone == 0, "R1 ready after reset", int'(ready), 0);
    chk(level == 0, "R1 level after reset", int'(level), 0);
    chk(pct == 100, "R1 pct after reset", int'(pct), 100);

    for (int v = 0; v < NVEC; v++) begin
      int exp_l;
      exp_l = VEC[v][4];
      burst(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      edges(WIN + 2 - e);
      chk(ready == 0, "R7 ready early", int'(ready), 0);
      edges(1);
      chk(ready == 1 && sdone == 1, "R7 ready on time", int'(ready), 1);
      // R2 R3 R5 R6
      chk(level == 4'(exp_l), "R3 locked level", int'(level), exp_l);
      chk(pct == 7'(PCT[exp_l]), "R4 pct", int'(pct), PCT[exp_l]);
      edges(1);
      chk(sdone == 0 && ready == 1, "R7 strobe one cycle", int'(sdone), 0);
      edges(200);
      chk(ready == 1 && level == 4'(exp_l), "R10 hold", int'(level), exp_l);
      prog = 1'b0;
      edges(3);
      chk(ready == 0 && level == 0, "R8 clear on low", int'(level), 0);
      edges(5);
    end

    // R9: line low at window close
    burst(60, 3, 2, 2);
    prog = 1'b0;
    edges(WIN + 3 - e);
    chk(ready == 0 && sdone == 0, "R9 no lock when low", int'(ready), 0);
    edges(50);
    chk(ready == 0 && level == 0, "R9 stays idle", int'(level), 0);

    // R8: fresh burst after low reloads a new code
    burst(60, 2, 2, 2);
    edges(WIN + 3 - e);
    chk(ready == 1 && level == 2, "R8 fresh burst", int'(level), 2);
    prog = 1'b0;
    edges(3);
    burst(60, 9, 2, 2);
    edges(WIN + 3 - e);
    chk(ready == 1 && level == 9, "R8 reload", int'(level), 9);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule